// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a binary up/down counter, four bits wide by default, that moves on rising edges of two separate strobe inputs. One strobe adds one to the count. The other strobe subtracts one. Each strobe is accepted only while the opposite strobe is held high. Everything runs on a single system clock. Both strobes pass through a synchronizer chain, and their rising edges are detected on that clock, so the strobes may be generated in another timing domain.

A level-sensitive active-low preset control copies the preset bus into the count. A level-sensitive active-high clear forces the count to zero and wins over preset and counting. Two active-low terminal-count flags mark the top count while the up strobe is low and the zero count while the down strobe is low. They behave as half-period pulses, so they can drive the strobes of a further stage.

Top module: `bidir_strobe_counter`

## Requirements
- R1: A rising edge of `up_strobe` while `dn_strobe` is high adds one to `count`, wrapping from 15 to 0. The new value appears on the third rising clock edge after the strobe rises.
- R2: A rising edge of `dn_strobe` while `up_strobe` is high subtracts one from `count`, wrapping from 0 to 15, with the same latency as R1.
- R3: A rising edge of either strobe while the opposite strobe is low leaves `count` unchanged.
- R4: While `load_n` is 0 and `clear` is 0, `count` takes the value on `preset` at every clock edge.
- R5: While `clear` is 1, `count` becomes 0 at the next clock edge, whatever `load_n`, `preset` and the strobes are doing.
- R6: A strobe rising edge that falls while load or clear is active is ignored. A strobe that is already high when load is released causes no count.
- R7: When rising edges of both strobes are detected in the same clock cycle, `count` is unchanged.
- R8: `tc_up_n` is 0 exactly while `count` is 15 and the up strobe is low. It returns to 1 in the same clock cycle as the count wraps to 0.
- R9: `tc_dn_n` is 0 exactly while `count` is 0 and the down strobe is low. It returns to 1 in the same clock cycle as the count wraps to 15.
- R10: While `rst_n` is 0, `count` is 0 and both flags are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| up_strobe | input | 1 | Count-up strobe; acts on its rising edge |
| dn_strobe | input | 1 | Count-down strobe; acts on its rising edge |
| load_n | input | 1 | Active-low preset control, level-sensitive |
| clear | input | 1 | Active-high clear; overrides all other inputs |
| preset | input | WIDTH (4) | Value copied into the count while preset is active |
| count | output | WIDTH (4) | Current count |
| tc_up_n | output | 1 | Active-low terminal count up |
| tc_dn_n | output | 1 | Active-low terminal count down |

## Verification
Two functions can land in the same cycle. The first pair is an up edge and a down edge: the bench lowers both strobes and raises them together, so that both synchronized edges are detected in one clock cycle, and it judges that the count is unchanged. The second pair is a terminal-count flag release and the count wrap: the bench samples on the clock before and the clock after the wrap edge, and checks that the flag and the count change together. The clear/preset overlap is provoked by asserting both at once and expecting zero.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    // Action selected for the count register in one clock cycle.
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_INC    = 3'd1,
        ACT_DEC    = 3'd2,
        ACT_PRESET = 3'd3,
        ACT_CLEAR  = 3'd4
    } cnt_act_e;

endpackage

// File: rtl/bsc_strobe_sync.sv
// Synchronizer chain plus one delay flop for rising-edge detection.
// The flops reset to 1 (the idle level of a strobe), so no edge is seen
// after reset.
module bsc_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic lvl_o,
    output logic dly_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              dly;
    } sync_t;

    sync_t             st_d, st_q;
    logic [STAGES-1:0] chain_nx;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_nx = strobe_i;
        end else begin : g_multi
            assign chain_nx = {st_q.chain[STAGES-2:0], strobe_i};
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = chain_nx;
        st_d.dly   = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.chain[STAGES-1];
    assign dly_o  = st_q.dly;
    assign rise_o = st_q.chain[STAGES-1] & ~st_q.dly;
endmodule

// File: rtl/bsc_arbiter.sv
// Picks one count action per cycle: clear > preset > single strobe edge.
module bsc_arbiter
    import bsc_pkg::*;
(
    input  logic     clear_i,
    input  logic     load_n_i,
    input  logic     up_rise_i,
    input  logic     dn_rise_i,
    input  logic     up_lvl_i,
    input  logic     dn_lvl_i,
    output cnt_act_e act_o
);
    logic up_ok, dn_ok;

    always_comb begin
        // An edge only counts while the other strobe is sampled high.
        up_ok = up_rise_i & dn_lvl_i;
        dn_ok = dn_rise_i & up_lvl_i;
        if (clear_i) begin
            act_o = ACT_CLEAR;
        end else if (!load_n_i) begin
            act_o = ACT_PRESET;
        end else if (up_ok && !dn_ok) begin
            act_o = ACT_INC;
        end else if (dn_ok && !up_ok) begin
            act_o = ACT_DEC;
        end else begin
            act_o = ACT_HOLD;   // nothing, or both edges together
        end
    end
endmodule

// File: rtl/bsc_count_reg.sv
module bsc_count_reg
    import bsc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_act_e         act_i,
    input  logic [WIDTH-1:0] preset_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (act_i)
            ACT_CLEAR:  cnt_d.cnt = '0;
            ACT_PRESET: cnt_d.cnt = preset_i;
            ACT_INC:    cnt_d.cnt = cnt_q.cnt + ONE;
            ACT_DEC:    cnt_d.cnt = cnt_q.cnt - ONE;
            default:    cnt_d.cnt = cnt_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.cnt;
endmodule

// File: rtl/bsc_term_flags.sv
// The flags use the delayed strobe level, the same flop that closes the
// edge detector, so a flag releases in the cycle in which the count moves.
module bsc_term_flags #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count_i,
    input  logic             up_dly_i,
    input  logic             dn_dly_i,
    output logic             tc_up_n_o,
    output logic             tc_dn_n_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    always_comb begin
        tc_up_n_o = ~((count_i == TOP) & ~up_dly_i);
        tc_dn_n_o = ~((count_i == '0)  & ~dn_dly_i);
    end
endmodule

// File: rtl/bidir_strobe_counter.sv
module bidir_strobe_counter
    import bsc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_strobe,
    input  logic             dn_strobe,
    input  logic             load_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             tc_up_n,
    output logic             tc_dn_n
);
    localparam int NSTB = 2;   // index 0 = up, 1 = down

    logic [NSTB-1:0] stb_raw, stb_lvl, stb_dly, stb_rise;
    cnt_act_e        act;

    assign stb_raw = {dn_strobe, up_strobe};

    generate
        for (genvar i = 0; i < NSTB; i++) begin : g_sync
            bsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .strobe_i (stb_raw[i]),
                .lvl_o    (stb_lvl[i]),
                .dly_o    (stb_dly[i]),
                .rise_o   (stb_rise[i])
            );
        end
    endgenerate

    bsc_arbiter u_arb (
        .clear_i   (clear),
        .load_n_i  (load_n),
        .up_rise_i (stb_rise[0]),
        .dn_rise_i (stb_rise[1]),
        .up_lvl_i  (stb_lvl[0]),
        .dn_lvl_i  (stb_lvl[1]),
        .act_o     (act)
    );

    bsc_count_reg #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .preset_i (preset),
        .count_o  (count)
    );

    bsc_term_flags #(.WIDTH(WIDTH)) u_flags (
        .count_i   (count),
        .up_dly_i  (stb_dly[0]),
        .dn_dly_i  (stb_dly[1]),
        .tc_up_n_o (tc_up_n),
        .tc_dn_n_o (tc_dn_n)
    );
endmodule

// File: rtl/bsc_counter_chk.sv
module bsc_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             clear,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             tc_up_n,
    input logic             tc_dn_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R1 R2: with no clear or preset, the count moves by at most one step
    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n) |=> (count == $past(count) ||
                                count == $past(count) + ONE ||
                                count == $past(count) - ONE));

    // R4: preset copies the bus
    a_r4_preset_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_n) |=> count == $past(preset));

    // R5: clear wins
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);

    // R8: up flag only at the top count
    a_r8_tc_up_top: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_up_n |-> count == TOP);

    // R9: down flag only at zero
    a_r9_tc_dn_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_dn_n |-> count == '0);
endmodule

bind bidir_strobe_counter bsc_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .clear   (clear),
    .preset  (preset),
    .count   (count),
    .tc_up_n (tc_up_n),
    .tc_dn_n (tc_dn_n)
);

// File: tb/bidir_strobe_counter_tb.sv
`timescale 1ns/1ps
module bidir_strobe_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_strobe = 1'b1, dn_strobe = 1'b1;
    logic       load_n = 1'b1, clear = 1'b0;
    logic [3:0] preset = 4'd0;
    logic [3:0] count;
    logic       tc_up_n, tc_dn_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bidir_strobe_counter u_dut (
        .clk(clk), .rst_n(rst_n), .up_strobe(up_strobe), .dn_strobe(dn_strobe),
        .load_n(load_n), .clear(clear), .preset(preset),
        .count(count), .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n)
    );

    // Operations: 0 up pulse, 1 down pulse, 2 preset, 3 clear,
    // 4 both strobes together, 5 up while down low then down released.
    // Entry = {op, value, expected count}.
    localparam int NVEC = 12;
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd2, 4'd14, 4'd14},   // R4
        {4'd0, 4'd0,  4'd15},   // R1
        {4'd0, 4'd0,  4'd0 },   // R1 wrap
        {4'd1, 4'd0,  4'd15},   // R2 wrap
        {4'd1, 4'd0,  4'd14},   // R2
        {4'd3, 4'd0,  4'd0 },   // R5
        {4'd1, 4'd0,  4'd15},   // R2
        {4'd2, 4'd3,  4'd3 },   // R4
        {4'd0, 4'd0,  4'd4 },   // R1
        {4'd4, 4'd0,  4'd4 },   // R7
        {4'd5, 4'd0,  4'd3 },   // R3
        {4'd2, 4'd9,  4'd9 }    // R4
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic [3:0] val);
        case (op)
            4'd0: begin up_strobe = 0; wait_n(4); up_strobe = 1; wait_n(4); end
            4'd1: begin dn_strobe = 0; wait_n(4); dn_strobe = 1; wait_n(4); end
            4'd2: begin preset = val; load_n = 0; wait_n(2); load_n = 1; wait_n(2); end
            4'd3: begin clear = 1; wait_n(2); clear = 0; wait_n(2); end
            4'd4: begin up_strobe = 0; dn_strobe = 0; wait_n(4);
                        up_strobe = 1; dn_strobe = 1; wait_n(4); end
            default: begin
                dn_strobe = 0; wait_n(4);
                up_strobe = 0; wait_n(4); up_strobe = 1; wait_n(4);
                dn_strobe = 1; wait_n(4);
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        // R10: reset state
        check("R10 count", count, 4'd0);
        check("R10 tc_up_n", {3'd0, tc_up_n}, 4'd1);
        check("R10 tc_dn_n", {3'd0, tc_dn_n}, 4'd1);
        rst_n = 1;
        wait_n(3);

        for (int i = 0; i < NVEC; i++) begin
            do_op(VEC[i][11:8], VEC[i][7:4]);
            check($sformatf("R1-vector %0d (R1 R2 R3 R4 R5 R7 table)", i), count, VEC[i][3:0]);
        end

        // R6: edges during preset ignored, strobe high at release no count
        preset = 4'd7; load_n = 0; wait_n(2);
        up_strobe = 0; wait_n(4); up_strobe = 1; wait_n(4);
        load_n = 1; wait_n(5);
        check("R6 preset", count, 4'd7);
        clear = 1; wait_n(1);
        dn_strobe = 0; wait_n(4); dn_strobe = 1; wait_n(4);
        clear = 0; wait_n(5);
        check("R6 clear", count, 4'd0);

        // R5: clear beats preset
        preset = 4'd5; load_n = 0; clear = 1; wait_n(2);
        check("R5 over preset", count, 4'd0);
        clear = 0; load_n = 1; wait_n(2);

        // R8: up flag pulse and release with the wrap
        do_op(4'd2, 4'd15);
        up_strobe = 0; wait_n(4);
        check("R8 flag low", {3'd0, tc_up_n}, 4'd0);
        up_strobe = 1; wait_n(2);
        check("R8 count before wrap", count, 4'd15);
        check("R8 flag before wrap", {3'd0, tc_up_n}, 4'd0);
        wait_n(1);
        check("R8 count at wrap", count, 4'd0);
        check("R8 flag at wrap", {3'd0, tc_up_n}, 4'd1);
        wait_n(3);

        // R9: down flag pulse and release with the wrap
        dn_strobe = 0; wait_n(4);
        check("R9 flag low", {3'd0, tc_dn_n}, 4'd0);
        check("R9 up flag stays high", {3'd0, tc_up_n}, 4'd1);
        dn_strobe = 1; wait_n(2);
        check("R9 flag before wrap", {3'd0, tc_dn_n}, 4'd0);
        wait_n(1);
        check("R9 count at wrap", count, 4'd15);
        check("R9 flag at wrap", {3'd0, tc_dn_n}, 4'd1);
        wait_n(3);

        // R10: reset in mid-run
        rst_n = 0; wait_n(2);
        check("R10 count after reset", count, 4'd0);
        check("R10 flags after reset", {2'd0, tc_up_n, tc_dn_n}, 4'd3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule